// File: doc/BRIEF.md
# PLL Output Frequency Lock Verifier

This block decides whether a phase-locked loop has really reached its intended output frequency. It does not look at the loop's own lock flag, because that flag can read "locked" while the output sits at a wrong frequency. The block counts rising edges of a clock derived from the PLL output. The count runs over a fixed window timed by a free-running reference clock. The result is compared with an expected count and an allowed deviation, both supplied on ports. The tolerance is normally about one percent of the expected count, rounded. The outcome is a held pass or fail flag.

Two derived clocks are candidates, one from the transmit path and one from the receive path. Two select words name the PLL each path uses, and the value zero means this PLL. The transmit clock is measured whenever the transmit path uses this PLL. The receive clock is measured only when the transmit path uses another PLL and the receive path uses this one.

The edge counter lives in the measured clock's own domain. At the end of the window its Gray-coded value is carried into the reference domain through a two-flop synchronizer. The comparison waits out a fixed settle period first. A check starts by itself after reset and after the PLL power-down input is released. The restart input starts one at any time, for example after the reference clock has been lost and restored. There is no lock-flag input, so the verdict depends only on the measured count.

Top module: `pll_freq_verify`

## Requirements
- R1: The window length W is WINDOW reference cycles (default 16000), or WIN_SHORT cycles when SIM_SHORT is nonzero. Busy rises on the edge that samples restart. The verdict appears, and busy falls, exactly CLR_CYC + W + SETTLE_CYC + 1 reference cycles after that edge.
- R2: With count C, lock_ok is set when C is nonzero and |C - expect_cnt| <= tol_cnt. Otherwise lock_fail is set.
- R3: If no counted edge arrives during the window, lock_fail is set even when expect_cnt is within tol_cnt of zero.
- R4: The receive clock is measured when tx_sel != 0 and rx_sel == 0. In every other case the transmit clock is measured.
- R5: Edges are counted only while clk_en is 1. With clk_en held at 0 the count stays zero and the check fails.
- R6: lock_ok and lock_fail are never both 1. Once a verdict is set, it holds unchanged, whatever expect_cnt or tol_cnt do, until a restart, power-down or reset.
- R7: A one-cycle restart pulse in any state, including the middle of a window, clears both verdict flags and begins a fresh check whose timing follows R1.
- R8: While pll_pwrdn is 1 the block is idle with busy, lock_ok and lock_fail all 0. On release of pll_pwrdn, and after reset, a check starts without a restart pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock that times the window |
| ref_rst_n | input | 1 | Asynchronous active-low reset, reference domain |
| tx_clk | input | 1 | Transmit-path clock derived from the PLL |
| rx_clk | input | 1 | Receive-path clock derived from the PLL |
| tx_sel | input | SELW | PLL used by the transmit path, 0 = this PLL |
| rx_sel | input | SELW | PLL used by the receive path, 0 = this PLL |
| clk_en | input | 1 | Enable of the measured clock; counting only while 1 |
| pll_pwrdn | input | 1 | PLL power-down; release starts a check |
| restart | input | 1 | Single-cycle request for a new check |
| expect_cnt | input | CW | Expected edge count per window |
| tol_cnt | input | CW | Allowed absolute deviation from expect_cnt |
| busy | output | 1 | A check is in progress |
| lock_ok | output | 1 | Frequency verified within tolerance |
| lock_fail | output | 1 | Frequency outside tolerance or no edges |

## Verification
The bench builds the block with SIM_SHORT=1, WIN_SHORT=256, CLR_CYC=4 and SETTLE_CYC=16, so one check takes 277 reference cycles instead of more than sixteen thousand. That makes it practical to run about twenty complete checks. They cover both measured clocks, tolerance on both sides of the count, a dead clock, a disabled enable, and restart or power-down in mid-window. With a 4 ns transmit clock and a 5 ns receive clock against the 8 ns reference, the expected counts are about 512 and 410. That gap lets a check show which clock was measured.

// File: rtl/pll_freq_verify.sv
`timescale 1ns/1ps
module pll_freq_verify #(
  parameter int CW         = 18,
  parameter int SELW       = 2,
  parameter int WINDOW     = 16000,
  parameter int SIM_SHORT  = 0,
  parameter int WIN_SHORT  = 256,
  parameter int CLR_CYC    = 4,
  parameter int SETTLE_CYC = 16
) (
  input  logic            ref_clk,
  input  logic            ref_rst_n,
  input  logic            tx_clk,
  input  logic            rx_clk,
  input  logic [SELW-1:0] tx_sel,
  input  logic [SELW-1:0] rx_sel,
  input  logic            clk_en,
  input  logic            pll_pwrdn,
  input  logic            restart,
  input  logic [CW-1:0]   expect_cnt,
  input  logic [CW-1:0]   tol_cnt,
  output logic            busy,
  output logic            lock_ok,
  output logic            lock_fail
);
  localparam int WIN = (SIM_SHORT != 0) ? WIN_SHORT : WINDOW;
  localparam int TW  = $clog2(WIN + CLR_CYC + SETTLE_CYC + 1);

  localparam logic [2:0] S_IDLE = 3'd0, S_CLEAR = 3'd1, S_COUNT = 3'd2,
                         S_SETTLE = 3'd3, S_CMP = 3'd4, S_DONE = 3'd5;

  logic [2:0]    st, st_d;
  logic [TW-1:0] tmr;
  logic          pend, clr_q, run_q;

  always_comb begin
    st_d = st;
    case (st)
      S_IDLE:   if (pend) st_d = S_CLEAR;
      S_CLEAR:  if (tmr == TW'(CLR_CYC - 1)) st_d = S_COUNT;
      S_COUNT:  if (tmr == TW'(WIN - 1)) st_d = S_SETTLE;
      S_SETTLE: if (tmr == TW'(SETTLE_CYC - 1)) st_d = S_CMP;
      S_CMP:    st_d = S_DONE;
      default:  st_d = S_DONE;
    endcase
    if (restart)   st_d = S_CLEAR;
    if (pll_pwrdn) st_d = S_IDLE;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      st    <= S_IDLE;
      tmr   <= '0;
      pend  <= 1'b1;
      clr_q <= 1'b1;
      run_q <= 1'b0;
    end else begin
      st    <= st_d;
      tmr   <= (st_d != st || restart) ? '0 : tmr + 1'b1;
      clr_q <= (st_d == S_CLEAR);
      run_q <= (st_d == S_COUNT);
      if (pll_pwrdn)         pend <= 1'b1;
      else if (st == S_IDLE) pend <= 1'b0;
    end
  end

  assign busy = (st != S_IDLE) && (st != S_DONE);

  // measured-clock domain: cleared asynchronously so a dead clock still reads zero
  logic          use_rx, mclk, run_m1, run_m2;
  logic [CW-1:0] cnt_m, cnt_d, gray_m;

  assign use_rx = (tx_sel != '0) && (rx_sel == '0);
  assign mclk   = use_rx ? rx_clk : tx_clk;
  assign cnt_d  = (run_m2 && clk_en && cnt_m != '1) ? cnt_m + 1'b1 : cnt_m;

  always_ff @(posedge mclk or posedge clr_q) begin
    if (clr_q) begin
      run_m1 <= 1'b0;
      run_m2 <= 1'b0;
      cnt_m  <= '0;
      gray_m <= '0;
    end else begin
      run_m1 <= run_q;
      run_m2 <= run_m1;
      cnt_m  <= cnt_d;
      gray_m <= cnt_d ^ (cnt_d >> 1);
    end
  end

  // reference domain: synchronize the frozen Gray count, decode, compare
  logic [CW-1:0] gs1, gs2, cnt_ref, diff;
  logic          pass;

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      gs1 <= '0;
      gs2 <= '0;
    end else if (st == S_CLEAR) begin
      gs1 <= '0;
      gs2 <= '0;
    end else begin
      gs1 <= gray_m;
      gs2 <= gs1;
    end
  end

  always_comb begin
    cnt_ref[CW-1] = gs2[CW-1];
    for (int i = CW - 2; i >= 0; i--) cnt_ref[i] = cnt_ref[i+1] ^ gs2[i];
  end

  assign diff = (cnt_ref >= expect_cnt) ? cnt_ref - expect_cnt : expect_cnt - cnt_ref;
  assign pass = (cnt_ref != '0) && (diff <= tol_cnt);

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      lock_ok   <= 1'b0;
      lock_fail <= 1'b0;
    end else if (pll_pwrdn || restart) begin
      lock_ok   <= 1'b0;
      lock_fail <= 1'b0;
    end else if (st == S_CMP) begin
      lock_ok   <= pass;
      lock_fail <= !pass;
    end
  end
endmodule

module pll_freq_verify_chk #(parameter int CW = 18) (
  input logic          ref_clk,
  input logic          ref_rst_n,
  input logic          restart,
  input logic          pll_pwrdn,
  input logic          busy,
  input logic          lock_ok,
  input logic          lock_fail,
  input logic [2:0]    st,
  input logic [CW-1:0] cnt_ref
);
  p_excl_r6: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !(lock_ok && lock_fail));
  p_hold_r6: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (st == 3'd5 && !restart && !pll_pwrdn) |=> ($stable(lock_ok) && $stable(lock_fail)));
  p_zero_fail_r3: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (st == 3'd4 && cnt_ref == '0 && !restart && !pll_pwrdn) |=> lock_fail);
  p_verdict_r2: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(lock_ok) |-> $past(st == 3'd4));
  p_restart_r7: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (restart && !pll_pwrdn) |=> (busy && !lock_ok && !lock_fail));
  p_pwrdn_r8: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    pll_pwrdn |=> (!busy && !lock_ok && !lock_fail));
endmodule

bind pll_freq_verify pll_freq_verify_chk #(.CW(CW)) u_chk (
  .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .restart(restart), .pll_pwrdn(pll_pwrdn),
  .busy(busy), .lock_ok(lock_ok), .lock_fail(lock_fail), .st(st), .cnt_ref(cnt_ref));

// File: tb/pll_freq_verify_tb.sv
`timescale 1ns/1ps
module pll_freq_verify_tb;
  localparam int CW = 18;
  localparam int TOTAL = 4 + 256 + 16 + 1;

  logic ref_clk = 0, ref_rst_n = 0, tx_clk = 0, rx_clk = 0;
  logic tx_run = 1, rx_run = 1;
  logic [1:0] tx_sel = 0, rx_sel = 0;
  logic clk_en = 1, pll_pwrdn = 0, restart = 0;
  logic [CW-1:0] expect_cnt = 512, tol_cnt = 5;
  logic busy, lock_ok, lock_fail;
  int checks = 0, errors = 0;

  always #4 ref_clk = ~ref_clk;
  always begin #2;   if (tx_run) tx_clk = ~tx_clk; end
  always begin #2.5; if (rx_run) rx_clk = ~rx_clk; end

  pll_freq_verify #(.CW(CW), .SIM_SHORT(1), .WIN_SHORT(256), .CLR_CYC(4), .SETTLE_CYC(16)) u_dut (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .tx_clk(tx_clk), .rx_clk(rx_clk),
    .tx_sel(tx_sel), .rx_sel(rx_sel), .clk_en(clk_en), .pll_pwrdn(pll_pwrdn),
    .restart(restart), .expect_cnt(expect_cnt), .tol_cnt(tol_cnt),
    .busy(busy), .lock_ok(lock_ok), .lock_fail(lock_fail));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      @(negedge ref_clk);
      if (!busy) break;
    end
  endtask

  task automatic run_check(input int e, input int t, input bit want_ok, input string tag);
    expect_cnt = CW'(e); tol_cnt = CW'(t);
    @(negedge ref_clk) restart = 1;
    @(negedge ref_clk) restart = 0;
    wait_done();
    chk(lock_ok == want_ok && lock_fail == !want_ok, tag, {lock_ok, lock_fail}, {want_ok, !want_ok});
  endtask

  task automatic t_reset();
    chk(!busy && !lock_ok && !lock_fail, "R8 reset state", {busy, lock_ok, lock_fail}, 0);
    @(negedge ref_clk) ref_rst_n = 1;
    @(negedge ref_clk);
    chk(busy, "R8 auto start after reset", busy, 1);
    wait_done();
    chk(lock_ok && !lock_fail, "R8 R2 auto check pass", {lock_ok, lock_fail}, 2);
  endtask

  task automatic t_tolerance();
    run_check(600, 6, 0, "R2 wrong frequency fails");
    run_check(520, 3, 0, "R2 count below tolerance band");
    run_check(520, 12, 1, "R2 count inside band from above");
    run_check(505, 12, 1, "R2 count inside band from below");
    run_check(505, 2, 0, "R2 count above tolerance band");
  endtask

  task automatic t_select();
    tx_sel = 1; rx_sel = 0;
    run_check(410, 4, 1, "R4 receive clock measured");
    run_check(512, 5, 0, "R4 transmit clock not measured");
    tx_sel = 1; rx_sel = 2;
    run_check(512, 5, 1, "R4 transmit clock when rx_sel nonzero");
    tx_sel = 0; rx_sel = 0;
    run_check(512, 5, 1, "R4 transmit clock when tx_sel zero");
  endtask

  task automatic t_zero();
    tx_run = 0;
    run_check(0, 5, 0, "R3 dead clock fails");
    tx_run = 1;
    clk_en = 0;
    run_check(512, 5, 0, "R5 enable low fails");
    run_check(0, 5, 0, "R5 R3 enable low counts zero");
    clk_en = 1;
  endtask

  task automatic t_hold();
    run_check(512, 5, 1, "R6 pass before hold");
    expect_cnt = 100; tol_cnt = 0;
    repeat (50) @(negedge ref_clk);
    chk(lock_ok && !lock_fail && !busy, "R6 verdict held", {busy, lock_ok, lock_fail}, 2);
  endtask

  task automatic t_timing();
    int n;
    expect_cnt = 512; tol_cnt = 5;
    @(negedge ref_clk) restart = 1;
    @(negedge ref_clk) restart = 0;
    chk(busy && !lock_ok && !lock_fail, "R7 restart clears verdict", {busy, lock_ok, lock_fail}, 4);
    repeat (100) @(negedge ref_clk);
    restart = 1;
    @(posedge ref_clk);
    @(negedge ref_clk) restart = 0;
    n = 0;
    do begin
      @(posedge ref_clk); n++;
      @(negedge ref_clk);
    end while (busy && n < 2000);
    chk(n == TOTAL, "R1 R7 cycles to verdict after mid-window restart", n, TOTAL);
    chk(lock_ok, "R7 restarted check passes", lock_ok, 1);
  endtask

  task automatic t_pwrdn();
    @(negedge ref_clk) restart = 1;
    @(negedge ref_clk) restart = 0;
    repeat (60) @(negedge ref_clk);
    pll_pwrdn = 1;
    repeat (5) @(negedge ref_clk);
    chk(!busy && !lock_ok && !lock_fail, "R8 idle during power-down", {busy, lock_ok, lock_fail}, 0);
    pll_pwrdn = 0;
    repeat (2) @(negedge ref_clk);
    chk(busy, "R8 check starts on release", busy, 1);
    wait_done();
    chk(lock_ok && !lock_fail, "R8 check after release passes", {lock_ok, lock_fail}, 2);
  endtask

  initial begin
    repeat (3) @(negedge ref_clk);
    t_reset();
    t_tolerance();
    t_select();
    t_zero();
    t_hold();
    t_timing();
    t_pwrdn();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge ref_clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule